// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Logic

This block is the receive half of a 16550-style UART register interface. A receiver that has already deserialized a character hands it over as a one-cycle valid pulse with a data byte. The byte lands in a receive queue that software drains through a single receive buffer register: each read strobe removes the oldest byte, and the next byte appears on the read data port.

Two operating modes exist. With the queue disabled the buffer holds exactly one byte and raises an interrupt whenever it is occupied. With the queue enabled it holds up to `DEPTH` bytes. The data interrupt and a DMA request then follow a programmable fill threshold. A separate inactivity time-out drives the same interrupt line and is told apart only by the identification code. The time-out fires after four character times with data present and no push or pop. Line status gives a data-ready flag and a sticky overrun flag for bytes that could not be stored.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset the block is in non-FIFO mode with threshold code 00. `data_ready`, `overrun`, `irq` and `dma_req` are 0, and `iid` is 4'b0001.
- R2: In FIFO mode, `rbr_data` shows the oldest stored byte and `rbr_rd` removes it, so bytes come out in arrival order. `rbr_data` reads 0 when empty, and a read of an empty buffer changes nothing.
- R3: `data_ready` is 1 exactly while at least one unread byte is stored.
- R4: In non-FIFO mode the buffer holds one byte. While it is occupied, `irq` is 1 with `iid` 4'b0100. A byte arriving while it is occupied is dropped and sets `overrun`.
- R5: In FIFO mode, `ctl_trig` codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 bytes. The data interrupt is asserted while the fill count is at or above the threshold and drops as soon as the count falls below it.
- R6: A control write changes the threshold only if FIFO mode was already enabled before that write and the write keeps it enabled; otherwise the threshold is left unchanged.
- R7: A control write that changes `ctl_fifo_en` from its current value discards all stored bytes, any byte arriving in that cycle, and a pending time-out.
- R8: In FIFO mode with at least one byte stored, 4*`CHAR_CYCLES` consecutive cycles without a push or pop raise the time-out. It asserts `irq`, and `iid` is 4'b1100 when the data interrupt is not active. Non-FIFO mode never raises it.
- R9: `iid` gives priority to received data (4'b0100) over time-out (4'b1100). It reads 4'b0001 with nothing pending, and `irq` is 1 exactly when `iid` bit 0 is 0.
- R10: A buffer read clears a pending time-out and restarts the inactivity count. An arriving byte restarts the count but leaves a pending time-out set.
- R11: `dma_req` is 1 exactly when the data interrupt condition holds: fill count at or above the threshold in FIFO mode, buffer occupied in non-FIFO mode.
- R12: A byte that arrives when the queue holds `DEPTH` bytes (FIFO mode) is dropped and sets `overrun`. `overrun` stays set until an `lsr_rd` strobe with no new drop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_data` |
| rx_data | input | DW | Received byte |
| rbr_rd | input | 1 | Receive buffer read strobe (pops oldest byte) |
| rbr_data | output | DW | Oldest unread byte, 0 when empty |
| lsr_rd | input | 1 | Line status read strobe (clears overrun) |
| ctl_wr | input | 1 | FIFO control register write strobe |
| ctl_fifo_en | input | 1 | Written FIFO enable value |
| ctl_trig | input | 2 | Written threshold code |
| data_ready | output | 1 | At least one unread byte present |
| overrun | output | 1 | Sticky: a byte was dropped |
| irq | output | 1 | Receive interrupt (data or time-out) |
| iid | output | 4 | Interrupt identification code |
| dma_req | output | 1 | Receive DMA request level |

## Verification
The bench keeps `DEPTH` at 16 and sets `CHAR_CYCLES` to 4, so the time-out window is 16 cycles. That short window lets idle gaps in random traffic cross the window, and directed checks can hit both the last quiet cycle and the firing cycle. With a 16-entry queue and the 14-byte threshold, the full-queue drop and the threshold edges occur within a few dozen pushes. Random traffic also toggles the mode and threshold mid-stream, which exercises flushing and ignored threshold writes.

// File: rtl/uart_rx_pkg.sv
// Package: shared codes and the threshold decode for the UART receive path.
// Assumes the threshold code is two bits wide.
package uart_rx_pkg;

    localparam logic [3:0] IID_NONE    = 4'b0001;
    localparam logic [3:0] IID_RX_DATA = 4'b0100;
    localparam logic [3:0] IID_TIMEOUT = 4'b1100;

    // Map a threshold code onto a byte count.
    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_queue.sv
// Receive byte queue: circular store with read/write pointers and a fill count.
// Assumes the caller never pushes beyond DEPTH and never pops when empty;
// a flush empties the queue and overrides push and pop.
module uart_rx_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the arriving byte into its slot.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Maintain pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest byte, or zero when nothing is stored.
    always_comb begin
        head_data = (count != '0) ? store[rd_ptr] : '0;
    end

    assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_pop_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush) |=> (count == $past(count) - 1'b1));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

// File: rtl/uart_rx_timeout.sv
// Character time-out detector: counts quiet cycles while data is held.
// Assumes 'armed' is true only in FIFO mode with data stored; 'clear'
// covers reads, flushes and disarming; 'activity' is any push.
module uart_rx_timeout #(
    parameter int CHAR_CYCLES = 16,
    localparam int LIMIT      = 4 * CHAR_CYCLES,
    localparam int TW         = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic clear,
    input  logic activity,
    output logic to_flag
);

    logic [TW-1:0] quiet_cnt;

    // Count quiet cycles and raise the flag on the last one of the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            quiet_cnt <= '0;
            to_flag   <= 1'b0;
        end else if (activity) begin
            quiet_cnt <= '0;
        end else if (!to_flag) begin
            if (quiet_cnt == TW'(LIMIT - 1)) begin
                to_flag <= 1'b1;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

    assert_to_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        to_flag |-> armed);

    assert_to_rises_when_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> $past(armed) && !$past(activity));

    assert_read_clears_to_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !to_flag);

endmodule

// File: rtl/uart_rx_irq.sv
// Interrupt encoder: derives the data condition from fill count and mode,
// merges it with the time-out flag, and forms the identification code.
// Assumes count never exceeds the queue depth.
module uart_rx_irq #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_code,
    input  logic [CW-1:0] count,
    input  logic          to_flag,
    output logic          irq,
    output logic [3:0]    iid,
    output logic          dma_req
);
    import uart_rx_pkg::*;

    logic rx_cond;

    // Data condition: threshold in FIFO mode, occupancy otherwise.
    always_comb begin
        if (fifo_en) begin
            rx_cond = (32'(count) >= trig_level(trig_code));
        end else begin
            rx_cond = (count != '0);
        end
    end

    // Priority-encode the pending source.
    always_comb begin
        if (rx_cond)      iid = IID_RX_DATA;
        else if (to_flag) iid = IID_TIMEOUT;
        else              iid = IID_NONE;
    end

    // Drive the shared interrupt line and the DMA request.
    always_comb begin
        irq     = rx_cond || to_flag;
        dma_req = rx_cond;
    end

    assert_irq_has_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !iid[0]);

    assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iid == IID_NONE));

    assert_dma_implies_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> irq && (count != '0));

endmodule

// File: rtl/uart_rx_fifo_irq.sv
// UART receive FIFO and interrupt logic, top level.
// Holds the FIFO control state (enable, threshold) and the sticky overrun
// flag, gates pushes by mode capacity, and ties queue, time-out detector
// and interrupt encoder together. Assumes rx_valid is a one-cycle pulse
// per character and that read strobes are one cycle per access.
module uart_rx_fifo_irq #(
    parameter int DW          = 8,
    parameter int DEPTH       = 16,
    parameter int CHAR_CYCLES = 16,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rbr_rd,
    output logic [DW-1:0] rbr_data,
    input  logic          lsr_rd,
    input  logic          ctl_wr,
    input  logic          ctl_fifo_en,
    input  logic [1:0]    ctl_trig,
    output logic          data_ready,
    output logic          overrun,
    output logic          irq,
    output logic [3:0]    iid,
    output logic          dma_req
);

    logic          fifo_en;
    logic [1:0]    trig_code;
    logic [CW-1:0] count;
    logic [CW-1:0] capacity;
    logic          flush;
    logic          push;
    logic          pop;
    logic          drop;
    logic          to_flag;
    logic          to_armed;
    logic          to_clear;

    // Decode control writes, capacity and the queue handshakes.
    always_comb begin
        flush    = ctl_wr && (ctl_fifo_en != fifo_en);
        capacity = fifo_en ? CW'(DEPTH) : CW'(1);
        push     = rx_valid && !flush && (count < capacity);
        drop     = rx_valid && !flush && (count >= capacity);
        pop      = rbr_rd && !flush && (count != '0);
        to_armed = fifo_en && (count != '0);
        to_clear = flush || pop || !to_armed;
    end

    // Hold the FIFO enable and threshold; the threshold needs FIFO mode first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en   <= 1'b0;
            trig_code <= 2'b00;
        end else if (ctl_wr) begin
            fifo_en <= ctl_fifo_en;
            if (fifo_en && ctl_fifo_en) begin
                trig_code <= ctl_trig;
            end
        end
    end

    // Sticky overrun: set on a dropped byte, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (lsr_rd) begin
            overrun <= 1'b0;
        end
    end

    uart_rx_queue #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head_data (rbr_data),
        .count     (count)
    );

    uart_rx_timeout #(
        .CHAR_CYCLES (CHAR_CYCLES)
    ) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (to_armed),
        .clear    (to_clear),
        .activity (push),
        .to_flag  (to_flag)
    );

    uart_rx_irq #(
        .CW (CW)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .trig_code (trig_code),
        .count     (count),
        .to_flag   (to_flag),
        .irq       (irq),
        .iid       (iid),
        .dma_req   (dma_req)
    );

    // Expose occupancy as the data-ready status bit.
    always_comb begin
        data_ready = (count != '0);
    end

    assert_trig_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !fifo_en) |=> (trig_code == $past(trig_code)));

    assert_nonfifo_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (count <= CW'(1)));

    assert_drop_sets_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !flush && (count == capacity)) |=> overrun);

    assert_ready_tracks_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && (count == CW'(1))) |=> !data_ready);

endmodule

// File: tb/tb_uart_rx_fifo_irq.sv
module tb_uart_rx_fifo_irq;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CHC   = 4;
    localparam int LIM   = 4 * CHC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rbr_rd = 1'b0;
    logic [DW-1:0] rbr_data;
    logic          lsr_rd = 1'b0;
    logic          ctl_wr = 1'b0;
    logic          ctl_fifo_en = 1'b0;
    logic [1:0]    ctl_trig = 2'b00;
    logic          data_ready;
    logic          overrun;
    logic          irq;
    logic [3:0]    iid;
    logic          dma_req;

    uart_rx_fifo_irq #(.DW(DW), .DEPTH(DEPTH), .CHAR_CYCLES(CHC)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rbr_rd(rbr_rd), .rbr_data(rbr_data), .lsr_rd(lsr_rd),
        .ctl_wr(ctl_wr), .ctl_fifo_en(ctl_fifo_en), .ctl_trig(ctl_trig),
        .data_ready(data_ready), .overrun(overrun), .irq(irq), .iid(iid),
        .dma_req(dma_req)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;

    // Reference model state
    logic [DW-1:0] q[$];
    logic m_fen = 1'b0;
    logic [1:0] m_trig = 2'b00;
    logic m_ovr = 1'b0;
    int   m_cnt = 0;
    logic m_to = 1'b0;

    function automatic int lvl_of(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic exp_rda();
        if (m_fen) return (q.size() >= lvl_of(m_trig));
        return (q.size() > 0);
    endfunction

    function automatic logic [3:0] exp_iid();
        if (exp_rda()) return 4'b0100;
        if (m_to) return 4'b1100;
        return 4'b0001;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update(input logic rv, input logic [DW-1:0] rx, input logic rd,
                                input logic cw, input logic cfen, input logic [1:0] ctr,
                                input logic lsr);
        int  sz = q.size();
        int  cap = m_fen ? DEPTH : 1;
        logic fl = cw && (cfen != m_fen);
        logic pp = rd && (sz > 0) && !fl;
        logic ps = rv && !fl && (sz < cap);
        logic ov = rv && !fl && (sz >= cap);
        if (fl || pp || !m_fen || sz == 0) begin
            m_cnt = 0; m_to = 1'b0;
        end else if (ps) begin
            m_cnt = 0;
        end else if (!m_to) begin
            if (m_cnt == LIM - 1) m_to = 1'b1;
            else m_cnt++;
        end
        if (fl) q.delete();
        else begin
            if (pp) void'(q.pop_front());
            if (ps) q.push_back(rx);
        end
        if (ov) m_ovr = 1'b1;
        else if (lsr) m_ovr = 1'b0;
        if (cw) begin
            if (m_fen && cfen) m_trig = ctr;
            m_fen = cfen;
        end
    endtask

    task automatic compare_all();
        chk("R3", "data_ready", 32'(data_ready), 32'(q.size() > 0));
        chk("R2", "rbr_data", 32'(rbr_data), (q.size() > 0) ? 32'(q[0]) : 32'd0);
        chk("R9", "iid", 32'(iid), 32'(exp_iid()));
        chk("R5", "irq", 32'(irq), 32'(exp_rda() || m_to));
        chk("R11", "dma_req", 32'(dma_req), 32'(exp_rda()));
        chk("R12", "overrun", 32'(overrun), 32'(m_ovr));
    endtask

    task automatic step(input logic rv, input logic [DW-1:0] rx, input logic rd,
                        input logic cw, input logic cfen, input logic [1:0] ctr,
                        input logic lsr);
        @(negedge clk);
        rx_valid = rv; rx_data = rx; rbr_rd = rd;
        ctl_wr = cw; ctl_fifo_en = cfen; ctl_trig = ctr; lsr_rd = lsr;
        @(posedge clk);
        #1;
        model_update(rv, rx, rd, cw, cfen, ctr, lsr);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 2'b00, 0);
    endtask

    task automatic push_b(input logic [DW-1:0] b);
        step(1, b, 0, 0, 0, 2'b00, 0);
    endtask

    task automatic pop_b();
        step(0, 8'h00, 1, 0, 0, 2'b00, 0);
    endtask

    task automatic ctl(input logic fen, input logic [1:0] tr);
        step(0, 8'h00, 0, 1, fen, tr, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                nfail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "data_ready", 32'(data_ready), 0);
        chk("R1", "overrun", 32'(overrun), 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "iid", 32'(iid), 32'h1);
        chk("R1", "dma_req", 32'(dma_req), 0);

        // R4: non-FIFO single byte holding
        push_b(8'hA5);
        chk("R4", "irq", 32'(irq), 1);
        chk("R4", "iid", 32'(iid), 32'h4);
        push_b(8'h3C);
        chk("R4", "overrun", 32'(overrun), 1);
        chk("R4", "rbr_data", 32'(rbr_data), 32'hA5);
        pop_b();
        chk("R3", "data_ready", 32'(data_ready), 0);
        // R8: no time-out in non-FIFO mode
        push_b(8'h11);
        idle(LIM + 4);
        chk("R8", "iid non-fifo", 32'(iid), 32'h4);
        pop_b();
        step(0, 8'h00, 0, 0, 0, 2'b00, 1);
        chk("R12", "overrun cleared", 32'(overrun), 0);

        // R6: threshold write ignored while enabling
        ctl(1, 2'b10);
        push_b(8'h21);
        chk("R6", "irq at level1", 32'(irq), 1);
        ctl(1, 2'b10);
        chk("R6", "irq after level8", 32'(irq), 0);
        for (int i = 0; i < 6; i++) push_b(8'(8'h30 + i));
        chk("R5", "irq at 7 of 8", 32'(irq), 0);
        push_b(8'h40);
        chk("R5", "irq at 8", 32'(irq), 1);
        chk("R11", "dma at 8", 32'(dma_req), 1);
        pop_b();
        chk("R5", "irq at 7", 32'(irq), 0);

        // R8: time-out after LIM quiet cycles
        idle(LIM - 1);
        chk("R8", "irq before window", 32'(irq), 0);
        idle(1);
        chk("R8", "irq time-out", 32'(irq), 1);
        chk("R8", "iid time-out", 32'(iid), 32'hC);
        push_b(8'h55);
        chk("R9", "iid priority", 32'(iid), 32'h4);
        chk("R10", "push keeps flag", 32'(irq), 1);
        pop_b();
        chk("R10", "read clears", 32'(irq), 0);
        idle(LIM - 1);
        chk("R10", "count restarted", 32'(irq), 0);

        // R7: disabling discards contents
        ctl(0, 2'b00);
        chk("R7", "data_ready", 32'(data_ready), 0);
        chk("R7", "irq", 32'(irq), 0);

        // R12: full queue in FIFO mode
        ctl(1, 2'b00);
        ctl(1, 2'b11);
        for (int i = 0; i < 13; i++) push_b(8'(8'h80 + i));
        chk("R5", "irq at 13 of 14", 32'(irq), 0);
        push_b(8'h8D);
        chk("R5", "irq at 14", 32'(irq), 1);
        push_b(8'h8E);
        push_b(8'h8F);
        chk("R12", "overrun before full", 32'(overrun), 0);
        push_b(8'hEE);
        chk("R12", "overrun on full", 32'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            chk("R2", "order", 32'(rbr_data), 32'(8'h80 + i));
            pop_b();
        end
        chk("R2", "empty after 16", 32'(data_ready), 0);
        pop_b();
        chk("R2", "read empty", 32'(rbr_data), 0);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            logic rv, rd, cw, cfen, lsr;
            logic [1:0] tr;
            logic [DW-1:0] b;
            if (($urandom % 40) == 0) begin
                idle(int'($urandom % (LIM + 6)));
            end
            rv = (($urandom % 10) < 4);
            rd = (($urandom % 10) < 3);
            cw = (($urandom % 60) == 0);
            cfen = (($urandom % 4) != 0);
            tr = 2'($urandom);
            lsr = (($urandom % 20) == 0);
            b = 8'($urandom);
            if (cw) step(0, b, 0, 1, cfen, tr, 0);
            else step(rv, b, rd, 0, 0, 2'b00, lsr);
        end
        finish_run();
    end

endmodule